// File: doc/BRIEF.md
# Power Switch Fault Supervisor

This block sequences the turn-on of a power path switch and watches it for failure, working only from digitized comparator flags. When a start request arrives it first looks at whether the drop across the switch is already too small. A small drop suggests the drain and source are shorted. In that case it turns on an output discharge path and waits, for a bounded number of cycles, for the output to fall below the feedback threshold. Only after this pre-check does it enable the gate driver.

After the gate driver is enabled, the block checks two things. During ramp it watches for gate-source overdrive to appear within a start-up window. In the on state it watches for that overdrive to disappear. A separate check runs at all times: it looks for the gate sitting near the input while the switch is commanded off. Any failure does three things at once: it drops the gate enable, it raises a latched fault, and it records the first cause in a two-bit code. A dedicated clear input returns the block to idle, and from there the next turn-on repeats the drain-source pre-check.

Top module: `psw_guard`

## Requirements
- R1: After reset the gate enable, the discharge enable and the fault flag are low, and the fault code is 00.
- R2: In idle, a high start request with the drain-source flag high moves the block to discharge on the next cycle, with discharge enable high and gate enable low. With the drain-source flag low, the gate enable rises on the next cycle instead.
- R3: In discharge, if the output-low flag is seen in any of the first DIS_CYC cycles, the gate enable rises on the next cycle. If it is not seen, the fault rises after exactly DIS_CYC discharge cycles with code 01.
- R4: While the gate enable is low and no fault is latched, a high gate-near-input flag raises the fault on the next cycle with code 10. While the gate enable is high, the flag has no effect.
- R5: During ramp, if the overdrive flag is seen in any of the first SU_CYC cycles, the block enters the on state with the gate enable kept high. If it is not seen, the fault rises after exactly SU_CYC ramp cycles with code 11.
- R6: In the on state, a low overdrive flag raises the fault on the next cycle with code 11. A low start request with the overdrive flag high returns the block to idle, with the gate enable low.
- R7: While the fault is latched, the gate enable and the discharge enable stay low and the start request is ignored.
- R8: The fault code keeps the first cause until a clear; a later failure seen while latched does not change it.
- R9: A clear pulse while the fault is latched returns the block to idle with code 00. A clear pulse in any other state has no effect.
- R10: The gate enable and the discharge enable are never high in the same cycle.
- R11: In discharge, a gate-near-input flag takes priority over the discharge timeout (code 10). In ramp, overdrive that arrives in the last window cycle takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Turn-on request (level) |
| clr_i | input | 1 | Fault clear pulse |
| ds_low_i | input | 1 | Input-minus-output below the drain-source threshold |
| out_low_i | input | 1 | Output below the feedback threshold |
| gate_hi_i | input | 1 | Gate voltage near input |
| ovd_ok_i | input | 1 | Gate-source overdrive reached |
| gate_en_o | output | 1 | Gate driver enable |
| dis_en_o | output | 1 | Output discharge enable |
| fault_o | output | 1 | Latched fault flag |
| fault_code_o | output | 2 | First fault cause: 01 drain-source, 10 gate-drain, 11 gate-source |

## Verification
The hardest cases to reach are the timeout boundaries. These are the exact cycle in which a late output-low or overdrive flag still wins, and the cycle in which it no longer does. The stimulus sweeps the arrival cycle of that flag from zero to one past each window, on a small configuration. For each arrival cycle it predicts either success or a fault with a computed code, and it counts the cycles in which discharge or gate enable must stay high. Priority collisions are forced by raising a second flag in the very cycle the timer expires.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DISCH = 3'd1,
        ST_RAMP  = 3'd2,
        ST_ON    = 3'd3,
        ST_FAULT = 3'd4
    } psw_state_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_DS   = 2'b01,
        FC_GD   = 2'b10,
        FC_GS   = 2'b11
    } psw_code_e;

    typedef struct packed {
        psw_state_e st;
        logic       gate;
        logic       dis;
    } psw_ctl_t;

endpackage

// File: rtl/psw_tmr.sv
module psw_tmr #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/psw_code_latch.sv
module psw_code_latch
    import psw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_i,
    input  psw_code_e code_i,
    input  logic      clr_i,
    output psw_code_e code_o
);
    psw_code_e code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (clr_i) begin
            code_d = FC_NONE;
        end else if (set_i && code_q == FC_NONE) begin
            code_d = code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= FC_NONE;
        else        code_q <= code_d;
    end

    assign code_o = code_q;
endmodule

// File: rtl/psw_guard.sv
module psw_guard
    import psw_pkg::*;
#(
    parameter int DIS_CYC = 64,
    parameter int SU_CYC  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       clr_i,
    input  logic       ds_low_i,
    input  logic       out_low_i,
    input  logic       gate_hi_i,
    input  logic       ovd_ok_i,
    output logic       gate_en_o,
    output logic       dis_en_o,
    output logic       fault_o,
    output logic [1:0] fault_code_o
);
    psw_ctl_t  ctl_d, ctl_q;
    logic      dis_hit, su_hit;
    logic      gd_flt;
    logic      set_flt;
    psw_code_e new_code;
    psw_code_e cur_code;
    logic      clr_go;

    // Dedicated window counters, each cleared while outside its state.
    psw_tmr #(.LIMIT(DIS_CYC)) u_dis_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (ctl_q.st == ST_DISCH),
        .hit_o (dis_hit)
    );

    psw_tmr #(.LIMIT(SU_CYC)) u_su_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (ctl_q.st == ST_RAMP),
        .hit_o (su_hit)
    );

    // Gate seen high although commanded low.
    assign gd_flt = gate_hi_i && !ctl_q.gate;

    always_comb begin
        ctl_d    = ctl_q;
        set_flt  = 1'b0;
        new_code = FC_NONE;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (gd_flt) begin
                    ctl_d.st = ST_FAULT; set_flt = 1'b1; new_code = FC_GD;
                end else if (start_i) begin
                    ctl_d.st = ds_low_i ? ST_DISCH : ST_RAMP;
                end
            end
            ST_DISCH: begin
                if (gd_flt) begin
                    ctl_d.st = ST_FAULT; set_flt = 1'b1; new_code = FC_GD;
                end else if (!start_i) begin
                    ctl_d.st = ST_IDLE;
                end else if (out_low_i) begin
                    ctl_d.st = ST_RAMP;
                end else if (dis_hit) begin
                    ctl_d.st = ST_FAULT; set_flt = 1'b1; new_code = FC_DS;
                end
            end
            ST_RAMP: begin
                if (!start_i) begin
                    ctl_d.st = ST_IDLE;
                end else if (ovd_ok_i) begin
                    ctl_d.st = ST_ON;
                end else if (su_hit) begin
                    ctl_d.st = ST_FAULT; set_flt = 1'b1; new_code = FC_GS;
                end
            end
            ST_ON: begin
                if (!ovd_ok_i) begin
                    ctl_d.st = ST_FAULT; set_flt = 1'b1; new_code = FC_GS;
                end else if (!start_i) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (clr_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_FAULT;
        endcase
        ctl_d.gate = (ctl_d.st == ST_RAMP) || (ctl_d.st == ST_ON);
        ctl_d.dis  = (ctl_d.st == ST_DISCH) && !ctl_d.gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.gate <= 1'b0;
            ctl_q.dis  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clr_go = clr_i && (ctl_q.st == ST_FAULT);

    psw_code_latch u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_flt),
        .code_i (new_code),
        .clr_i  (clr_go),
        .code_o (cur_code)
    );

    assign gate_en_o    = ctl_q.gate;
    assign dis_en_o     = ctl_q.dis;
    assign fault_o      = (ctl_q.st == ST_FAULT);
    assign fault_code_o = cur_code;
endmodule

// File: rtl/psw_guard_chk.sv
module psw_guard_chk #(
    parameter int DIS_CYC = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_i,
    input logic       gate_hi_i,
    input logic       gate_en_o,
    input logic       dis_en_o,
    input logic       fault_o,
    input logic [1:0] fault_code_o
);
    int dis_run;

    always_ff @(posedge clk) begin
        if (!rst_n)        dis_run <= 0;
        else if (dis_en_o) dis_run <= dis_run + 1;
        else               dis_run <= 0;
    end

    AST_EXCL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en_o && dis_en_o)); // R10

    AST_FAULT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!gate_en_o && !dis_en_o)); // R7

    AST_GD_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en_o && gate_hi_i && !fault_o) |=> (fault_o && fault_code_o == 2'b10)); // R4

    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !clr_i) |=> (fault_o && $stable(fault_code_o))); // R8

    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && clr_i) |=> (!fault_o && fault_code_o == 2'b00)); // R9

    AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_code_o != 2'b00)); // R8

    AST_DIS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dis_en_o |-> (dis_run < DIS_CYC)); // R3
endmodule

bind psw_guard psw_guard_chk #(.DIS_CYC(DIS_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .gate_hi_i    (gate_hi_i),
    .gate_en_o    (gate_en_o),
    .dis_en_o     (dis_en_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o)
);

// File: tb/sim_psw_guard.sv
module sim_psw_guard;
    localparam int DIS = 4;
    localparam int SU  = 5;

    logic clk = 1'b0;
    logic rst_n, start_i, clr_i, ds_low_i, out_low_i, gate_hi_i, ovd_ok_i;
    logic gate_en_o, dis_en_o, fault_o;
    logic [1:0] fault_code_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psw_guard #(.DIS_CYC(DIS), .SU_CYC(SU)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i),
        .ds_low_i(ds_low_i), .out_low_i(out_low_i), .gate_hi_i(gate_hi_i),
        .ovd_ok_i(ovd_ok_i), .gate_en_o(gate_en_o), .dis_en_o(dis_en_o),
        .fault_o(fault_o), .fault_code_o(fault_code_o)
    );

    task automatic expect_out(string req, logic eg, logic ed, logic ef, logic [1:0] ec);
        n_chk++;
        if (gate_en_o !== eg || dis_en_o !== ed || fault_o !== ef || fault_code_o !== ec) begin
            n_bad++;
            $display("FAIL %s: got gate=%b dis=%b flt=%b code=%b, want gate=%b dis=%b flt=%b code=%b",
                     req, gate_en_o, dis_en_o, fault_o, fault_code_o, eg, ed, ef, ec);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        start_i = 0; clr_i = 0; ds_low_i = 0; out_low_i = 0; gate_hi_i = 0; ovd_ok_i = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung run, want completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        quiet();
        @(negedge clk);
        do_reset();
        expect_out("R1 reset", 0, 0, 0, 2'b00);

        // R3 / R2: discharge sweep over output-low arrival cycle k
        for (int k = 0; k <= DIS + 1; k++) begin
            int nt;
            do_reset();
            start_i = 1; ds_low_i = 1;
            tick();
            expect_out("R2 enter discharge", 0, 1, 0, 2'b00);
            ds_low_i = 0;
            nt = (k < DIS) ? k + 1 : DIS;
            for (int c = 0; c < nt; c++) begin
                out_low_i = (c >= k);
                tick();
                if (c < nt - 1) expect_out("R3 still discharging", 0, 1, 0, 2'b00);
            end
            if (k < DIS) expect_out("R3 discharge ok", 1, 0, 0, 2'b00);
            else         expect_out("R3 discharge timeout", 0, 0, 1, 2'b01);
        end

        // R5: ramp sweep over overdrive arrival cycle k, then R6 drop
        for (int k = 0; k <= SU + 1; k++) begin
            int nt;
            do_reset();
            start_i = 1;
            tick();
            expect_out("R2 direct ramp", 1, 0, 0, 2'b00);
            nt = (k < SU) ? k + 1 : SU;
            for (int c = 0; c < nt; c++) begin
                ovd_ok_i = (c >= k);
                tick();
                if (c < nt - 1) expect_out("R5 still ramping", 1, 0, 0, 2'b00);
            end
            if (k < SU) begin
                expect_out("R5 reached on", 1, 0, 0, 2'b00);
                gate_hi_i = 1; clr_i = 1;
                tick();
                expect_out("R4 R9 ignored while on", 1, 0, 0, 2'b00);
                gate_hi_i = 0; clr_i = 0;
                ovd_ok_i = 0;
                tick();
                expect_out("R6 overdrive drop", 0, 0, 1, 2'b11);
            end else begin
                expect_out("R5 ramp timeout", 0, 0, 1, 2'b11);
            end
        end

        // R4: gate-drain in idle
        do_reset();
        gate_hi_i = 1;
        tick();
        expect_out("R4 gd in idle", 0, 0, 1, 2'b10);
        // R7 R8: start ignored, later failure keeps first code
        gate_hi_i = 0; start_i = 1; ds_low_i = 1;
        tick(); tick();
        expect_out("R7 start ignored in fault", 0, 0, 1, 2'b10);
        // R9: clear, then recheck drain-source
        clr_i = 1;
        tick();
        clr_i = 0;
        expect_out("R9 clear to idle", 0, 0, 0, 2'b00);
        tick();
        expect_out("R9 recheck discharge", 0, 1, 0, 2'b00);

        // R11: gate-drain beats discharge timeout in same cycle
        do_reset();
        start_i = 1; ds_low_i = 1;
        tick();
        for (int c = 0; c < DIS; c++) begin
            gate_hi_i = (c == DIS - 1);
            tick();
        end
        expect_out("R11 gd over ds timeout", 0, 0, 1, 2'b10);

        // R8: gate-source fault then gate-drain while latched
        do_reset();
        start_i = 1;
        tick();
        for (int c = 0; c < SU; c++) tick();
        expect_out("R5 timeout for R8", 0, 0, 1, 2'b11);
        gate_hi_i = 1;
        tick();
        expect_out("R8 first code kept", 0, 0, 1, 2'b11);
        gate_hi_i = 0;

        // R6: normal turn-off from on
        do_reset();
        start_i = 1; ovd_ok_i = 1;
        tick(); tick();
        expect_out("R6 on", 1, 0, 0, 2'b00);
        start_i = 0;
        tick();
        expect_out("R6 turn off", 0, 0, 0, 2'b00);
        tick();
        expect_out("R6 idle stays", 0, 0, 0, 2'b00);

        // R9: clear in discharge has no effect
        do_reset();
        start_i = 1; ds_low_i = 1;
        tick();
        clr_i = 1;
        tick();
        clr_i = 0;
        expect_out("R9 clear ignored in discharge", 0, 1, 0, 2'b00);
        // R10 implicit in every check above; R2 withdraw in discharge
        start_i = 0;
        tick();
        expect_out("R10 R2 withdraw to idle", 0, 0, 0, 2'b00);

        finish_run();
    end
endmodule